// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from six external pins and presents one request at a time to a processor. There are 36 groups, each with a single request source and a single vector. Each group has a sticky pending flag, an enable bit and a programmable level. The arbiter hands the processor the number of the winning group directly, so the processor needs no software decode step.

Level 0 is the most urgent. Levels 0 to 6 are usable, and level 7 takes a group out of arbitration. The groups fall into twelve classes of three consecutive groups. Within a level, and within a class, the lower group number always wins. Groups 1 to 3 are meant for system sources and are fed from the internal request vector like any other group.

Each external pin passes through a two-flop synchroniser and then a detector. The detector can be set to fire on a rising edge, a falling edge, either edge, or while the pin is low. Pin k feeds group 30+k. Reset does not pass through the groups.

Top module: `gpic_top`

## Requirements
- R1: A one-cycle high on int_req[g] sets the pending flag of group g at the next clock edge. The flag stays set until software writes 1 to its clear bit. If a set and a clear reach the same flag in one cycle, the set wins.
- R2: A write to address g below 36 loads the level from wr_data[2:0] and the enable from wr_data[4], and clears the flag when wr_data[8] is 1. A read of address g returns the level in bits [2:0], the enable in bit 4 and the flag in bit 8. Addresses 36 to 62 read as zero.
- R3: A group whose enable is 0 still latches its flag, but it never wins arbitration.
- R4: A group is eligible when its flag and enable are both 1 and its level is 0 to 6; level 7 is never eligible. The winner is the eligible group with the numerically lowest level. On a tie, the lowest group number wins, which also orders the three groups inside each class.
- R5: irq_grp and irq_lvl are registered outputs. They show the winner one clock after the flags and settings that chose it. When no group is eligible they show group 0 and level 7.
- R6: irq_out is registered in the same cycle as irq_lvl. It is 1 only when a winner exists and its level is numerically lower than the cpu_mask value at that clock edge.
- R7: External pin k sets the flag of group 30+k through a two-flop synchroniser. The synchroniser resets to the high, idle value.
- R8: The trigger mode register is at address 63. Pin k uses bits [2k+1:2k]: 00 is rising edge, 01 falling edge, 10 either edge, 11 low level. The register resets to 0 and reads back what was written.
- R9: In low-level mode, the flag is set again on every cycle the synchronised pin is low. A clear therefore only takes effect once the pin has returned high.
- R10: rst_n low clears all flags and enables, sets every level to 7 and drives irq_out to 0. Reset asserts asynchronously and releases two clocks after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 36 | Internal request pulses, one per group |
| ext_pin | input | 6 | External interrupt pins, asynchronous |
| cpu_mask | input | 3 | Processor's current mask level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 12 | Register read data, combinational |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_lvl | output | 3 | Level of the winning group |
| irq_grp | output | 6 | Number of the winning group |

## Verification
The assertions assume that cpu_mask and the register write signals are stable around the clock edge. They also assume that int_req pulses on groups 30 to 35 do not overlap with pin events, since both set the same flag. The stimulus drives every input on the falling edge and keeps random internal pulses on groups 0 to 29. The external pins are exercised only in directed steps, with random traffic paused, so that the bench's flag model can track each source separately.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_NONE = '1;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_BOTH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;
endpackage

// File: rtl/gpic_ext_detect.sv
module gpic_ext_detect
  import gpic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  input  trig_e mode,
  output logic  evt
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_RISE: evt = sync_q & ~hist_q;
      TRIG_FALL: evt = ~sync_q & hist_q;
      TRIG_BOTH: evt = sync_q ^ hist_q;
      TRIG_LOW:  evt = ~sync_q;
      default:   evt = 1'b0;
    endcase
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_RISE && evt) |=> !(evt && mode == TRIG_RISE)); // R8

  AST_LOW_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LOW && $past(mode) == TRIG_LOW && !$past(meta_q)) |-> evt); // R9
endmodule

// File: rtl/gpic_group_bank.sv
module gpic_group_bank
  import gpic_pkg::*;
#(
  parameter int NUM_GROUPS = 36,
  localparam int GRP_W = $clog2(NUM_GROUPS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_GROUPS-1:0]             set_vec,
  input  logic                              wr_grp_en,
  input  logic [GRP_W-1:0]                  wr_grp,
  input  logic [LVL_W-1:0]                  wr_level,
  input  logic                              wr_enable,
  input  logic                              wr_clear,
  output logic [NUM_GROUPS-1:0]             flag_q,
  output logic [NUM_GROUPS-1:0]             en_q,
  output logic [NUM_GROUPS-1:0][LVL_W-1:0]  lvl_q
);
  logic [NUM_GROUPS-1:0]            sel_vec, clr_vec, flag_d, en_d;
  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_d;

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      sel_vec[g] = wr_grp_en && (wr_grp == GRP_W'(g));
    end
    clr_vec = sel_vec & {NUM_GROUPS{wr_clear}};
    flag_d  = (flag_q & ~clr_vec) | set_vec;
    en_d    = en_q;
    lvl_d   = lvl_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel_vec[g]) begin
        en_d[g]  = wr_enable;
        lvl_d[g] = wr_level;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      lvl_q  <= {NUM_GROUPS{LVL_NONE}};
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      lvl_q  <= lvl_d;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~clr_vec) != '0) |=> (($past(flag_q & ~clr_vec) & ~flag_q) == '0)); // R1

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (($past(set_vec) & ~flag_q) == '0)); // R1
endmodule

// File: rtl/gpic_prio_arbiter.sv
module gpic_prio_arbiter
  import gpic_pkg::*;
#(
  parameter int NUM_GROUPS = 36,
  localparam int GRP_W = $clog2(NUM_GROUPS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_GROUPS-1:0]             flag,
  input  logic [NUM_GROUPS-1:0]             en,
  input  logic [NUM_GROUPS-1:0][LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]                  cpu_mask,
  output logic                              irq_q,
  output logic [LVL_W-1:0]                  win_lvl_q,
  output logic [GRP_W-1:0]                  win_grp_q
);
  logic [LVL_W-1:0] best_lvl;
  logic [GRP_W-1:0] best_grp;
  logic             irq_d;

  always_comb begin
    best_lvl = LVL_NONE;
    best_grp = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (flag[g] && en[g] && (lvl[g] < best_lvl)) begin
        best_lvl = lvl[g];
        best_grp = GRP_W'(g);
      end
    end
    irq_d = (best_lvl != LVL_NONE) && (best_lvl < cpu_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      win_lvl_q <= LVL_NONE;
      win_grp_q <= '0;
    end else begin
      irq_q     <= irq_d;
      win_lvl_q <= best_lvl;
      win_grp_q <= best_grp;
    end
  end

  AST_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (win_lvl_q < $past(cpu_mask))); // R6

  AST_IRQ_REAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (win_lvl_q != LVL_NONE)); // R4
endmodule

// File: rtl/gpic_top.sv
module gpic_top
  import gpic_pkg::*;
#(
  parameter int NUM_GROUPS = 36,
  parameter int NUM_EXT    = 6,
  parameter int EXT_BASE   = 30,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 12,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int MODE_W    = 2 * NUM_EXT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_GROUPS-1:0]  int_req,
  input  logic [NUM_EXT-1:0]     ext_pin,
  input  logic [LVL_W-1:0]       cpu_mask,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   irq_out,
  output logic [LVL_W-1:0]       irq_lvl,
  output logic [GRP_W-1:0]       irq_grp
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = '1;
  localparam int BIT_EN  = 4;
  localparam int BIT_CLR = 8;

  logic                             rst_meta_q, rst_sync_n;
  logic [MODE_W-1:0]                mode_q, mode_d;
  logic [NUM_EXT-1:0]               ext_evt;
  logic [NUM_GROUPS-1:0]            set_vec, flag_q, en_q;
  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_q;
  logic                             grp_wr, mode_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign grp_wr  = wr_en && (wr_addr < ADDR_W'(NUM_GROUPS));
  assign mode_wr = wr_en && (wr_addr == MODE_ADDR);

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = wr_data[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= '0;
    else             mode_q <= mode_d;
  end

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    gpic_ext_detect u_det (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .pin   (ext_pin[k]),
      .mode  (trig_e'(mode_q[2*k+1:2*k])),
      .evt   (ext_evt[k])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_src
    if (g >= EXT_BASE && g < EXT_BASE + NUM_EXT) begin : g_pin
      assign set_vec[g] = int_req[g] | ext_evt[g-EXT_BASE];
    end else begin : g_int
      assign set_vec[g] = int_req[g];
    end
  end

  gpic_group_bank #(.NUM_GROUPS(NUM_GROUPS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_vec   (set_vec),
    .wr_grp_en (grp_wr),
    .wr_grp    (wr_addr[GRP_W-1:0]),
    .wr_level  (wr_data[LVL_W-1:0]),
    .wr_enable (wr_data[BIT_EN]),
    .wr_clear  (wr_data[BIT_CLR]),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .lvl_q     (lvl_q)
  );

  gpic_prio_arbiter #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flag      (flag_q),
    .en        (en_q),
    .lvl       (lvl_q),
    .cpu_mask  (cpu_mask),
    .irq_q     (irq_out),
    .win_lvl_q (irq_lvl),
    .win_grp_q (irq_grp)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == MODE_ADDR) begin
      rd_data[MODE_W-1:0] = mode_q;
    end else if (rd_addr < ADDR_W'(NUM_GROUPS)) begin
      rd_data[LVL_W-1:0] = lvl_q[rd_addr[GRP_W-1:0]];
      rd_data[BIT_EN]    = en_q[rd_addr[GRP_W-1:0]];
      rd_data[BIT_CLR]   = flag_q[rd_addr[GRP_W-1:0]];
    end
  end

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> ((($past(flag_q & en_q)) & (NUM_GROUPS'(1) << irq_grp)) != '0)); // R3

  AST_GRP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_grp < GRP_W'(NUM_GROUPS)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> !irq_out); // R10
endmodule

// File: tb/gpic_top_bench.sv
module gpic_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 36;
  localparam int NE = 6;
  localparam int EB = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NG-1:0] int_req;
  logic [NE-1:0] ext_pin;
  logic [2:0]    cpu_mask;
  logic          wr_en;
  logic [5:0]    wr_addr;
  logic [11:0]   wr_data;
  logic [5:0]    rd_addr;
  logic [11:0]   rd_data;
  logic          irq_out;
  logic [2:0]    irq_lvl;
  logic [5:0]    irq_grp;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_lvl  [NG];
  logic       m_en   [NG];
  logic       m_flag [NG];

  gpic_top u_gpic_top (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_pin(ext_pin),
    .cpu_mask(cpu_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out),
    .irq_lvl(irq_lvl), .irq_grp(irq_grp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NG) begin
      m_lvl[a] = d[2:0];
      m_en[a]  = d[4];
      if (d[8]) m_flag[a] = 1'b0;
    end
  endtask

  task automatic pulse(input logic [NG-1:0] v);
    @(negedge clk);
    int_req = v;
    @(negedge clk);
    int_req = '0;
    for (int g = 0; g < NG; g++) if (v[g]) m_flag[g] = 1'b1;
  endtask

  function automatic int exp_grp();
    int bl = 7, bg = 0;
    for (int g = 0; g < NG; g++)
      if (m_flag[g] && m_en[g] && m_lvl[g] < bl) begin bl = m_lvl[g]; bg = g; end
    return bg;
  endfunction

  function automatic int exp_lvl();
    int bl = 7;
    for (int g = 0; g < NG; g++)
      if (m_flag[g] && m_en[g] && m_lvl[g] < bl) bl = m_lvl[g];
    return bl;
  endfunction

  task automatic check_out(input string tag);
    int el, eg, eo;
    repeat (2) @(negedge clk);
    el = exp_lvl(); eg = exp_grp();
    eo = (el != 7 && el < int'(cpu_mask)) ? 1 : 0;
    chk(irq_lvl == el, {tag, " lvl"}, irq_lvl, el);
    chk(irq_grp == eg, {tag, " grp"}, irq_grp, eg);
    chk(irq_out == eo, {tag, " out"}, irq_out, eo);
  endtask

  task automatic read_flag(input int g, input int exp, input string tag);
    rd_addr = 6'(g);
    #1;
    chk(rd_data[8] == exp[0], tag, rd_data[8], exp);
  endtask

  task automatic set_mode(input int pin, input logic [1:0] m);
    logic [11:0] d = '0;
    d[2*pin +: 2] = m;
    reg_wr(6'd63, d);
  endtask

  task automatic pin_step(input int pin, input logic v);
    @(negedge clk);
    ext_pin[pin] = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; int_req = '0; ext_pin = '1; cpu_mask = 3'd7;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int g = 0; g < NG; g++) begin m_lvl[g] = 3'd7; m_en[g] = 1'b0; m_flag[g] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(irq_out == 1'b0, "R10 irq_out", irq_out, 0);
    rd_addr = 6'd5; #1;
    chk(rd_data == 12'h007, "R10 group reg", rd_data, 12'h007);
    rd_addr = 6'd63; #1;
    chk(rd_data == 12'h000, "R8 mode reset", rd_data, 0);
    rd_addr = 6'd40; #1;
    chk(rd_data == 12'h000, "R2 unused addr", rd_data, 0);

    // R2 readback
    reg_wr(6'd12, 12'h013);
    rd_addr = 6'd12; #1;
    chk(rd_data == 12'h013, "R2 readback", rd_data, 12'h013);

    // R3 disabled group latches but does not win
    reg_wr(6'd7, 12'h002);
    pulse(NG'(1) << 7);
    read_flag(7, 1, "R3 disabled flag latched");
    check_out("R3 disabled excluded");

    // R4 tie: groups 10 and 11 at level 2, lowest number wins
    reg_wr(6'd11, 12'h012);
    reg_wr(6'd10, 12'h012);
    pulse((NG'(1) << 10) | (NG'(1) << 11));
    check_out("R4 tie");
    chk(irq_grp == 6'd10, "R4 tie winner", irq_grp, 10);

    // R4 level 7 never eligible
    reg_wr(6'd2, 12'h017);
    pulse(NG'(1) << 2);
    check_out("R4 level7");

    // R6 mask equal to level gives no request
    cpu_mask = 3'd2;
    check_out("R6 mask equal");
    chk(irq_out == 1'b0, "R6 mask equal out", irq_out, 0);
    cpu_mask = 3'd3;
    check_out("R6 mask above");

    // R1 set wins over clear in same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd10; wr_data = 12'h112; int_req = NG'(1) << 10;
    @(negedge clk);
    wr_en = 1'b0; int_req = '0;
    read_flag(10, 1, "R1 set beats clear");
    reg_wr(6'd10, 12'h112);
    read_flag(10, 0, "R1 clear");
    check_out("R1 after clear");

    // R7 R8 external pin modes on pin 0 (group 30) and pin 3 (group 33)
    reg_wr(6'(EB), 12'h001);
    set_mode(0, 2'b00);
    pin_step(0, 1'b0);
    read_flag(EB, 0, "R8 rise ignores fall");
    pin_step(0, 1'b1);
    read_flag(EB, 1, "R7 rise sets flag");
    reg_wr(6'(EB), 12'h101);
    set_mode(0, 2'b01);
    pin_step(0, 1'b0);
    read_flag(EB, 1, "R8 fall sets flag");
    reg_wr(6'(EB), 12'h101);
    pin_step(0, 1'b1);
    read_flag(EB, 0, "R8 fall ignores rise");
    set_mode(0, 2'b10);
    pin_step(0, 1'b0);
    read_flag(EB, 1, "R8 both on fall");
    reg_wr(6'(EB), 12'h101);
    pin_step(0, 1'b1);
    read_flag(EB, 1, "R8 both on rise");
    reg_wr(6'(EB), 12'h107);
    set_mode(3, 2'b11);
    rd_addr = 6'd63; #1;
    chk(rd_data == 12'h0C0, "R8 mode readback", rd_data, 12'h0C0);
    pin_step(3, 1'b0);
    reg_wr(6'(EB+3), 12'h101);
    read_flag(EB+3, 1, "R9 level holds despite clear");
    pin_step(3, 1'b1);
    reg_wr(6'(EB+3), 12'h107);
    read_flag(EB+3, 0, "R9 clear after release");
    set_mode(0, 2'b00);

    // Random phase on groups 0..29
    for (int it = 0; it < 60; it++) begin
      for (int w = 0; w < 3; w++) begin
        logic [11:0] d = '0;
        d[2:0] = 3'($urandom_range(0, 7));
        d[4]   = 1'($urandom);
        d[8]   = ($urandom_range(0, 3) == 0);
        reg_wr(6'($urandom_range(0, 29)), d);
      end
      pulse(NG'(($urandom & $urandom & $urandom) & 32'h3FFF_FFFF));
      cpu_mask = 3'($urandom_range(0, 7));
      check_out("R4 R5 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule